// File: doc/BRIEF.md
# Pulse-Swallow Divider Controller

This block holds the counting and steering logic that sits behind a fixed dual-modulus N/N+1 prescaler in a frequency synthesizer. The prescaler output is its only clock. In each output cycle the block lets the prescaler divide by N+1 for a programmed number of its periods (the swallow count S). It then divides by N until a programmed total of prescaler periods (the program count P) has gone by. The ratio from the prescaler input to the divided output is therefore N·P+S, and it moves in steps of one as S changes. This gives single-step channel selection while the only logic running at the input rate is the prescaler itself.

The control is a three-state machine:
- `ST_LOAD` is entered from reset and lasts one prescaler period.
- `ST_WIDE` asserts modulus select, so the prescaler divides by N+1.
- `ST_NARROW` deasserts it, so the prescaler divides by N.

The transitions are:
- *load*: `ST_LOAD` → `ST_WIDE`, or → `ST_NARROW` when S is 0.
- *swallow-done*: `ST_WIDE` → `ST_NARROW` when the swallow counter reaches S.
- *restart*: `ST_WIDE`/`ST_NARROW` → `ST_WIDE`, or → `ST_NARROW` when the new S is 0. This happens when the program counter reaches P.

*restart* takes precedence over *swallow-done*. The programmed values are captured on *load* and on *restart* only.

Top module: `swallow_div_ctrl`

## Requirements
- R1: For 1 ≤ P ≤ 8191 and 0 ≤ S < P, the number of prescaler input clocks between successive cycle starts equals N·P+S.
- R2: `mod_sel_o` = 1 requests division by N+1 and 0 requests division by N. When S > 0, `mod_sel_o` is 1 during the first prescaler period of every cycle.
- R3: Each cycle spans exactly P prescaler periods, of which exactly S have `mod_sel_o` = 1.
- R4: Once `mod_sel_o` falls inside a cycle, it stays 0 until the next cycle starts.
- R5: `div_pulse_o` is 1 for exactly the first prescaler period of each cycle, giving one pulse per cycle when P > 1.
- R6: P and S are sampled only at a cycle start. A change in the middle of a cycle leaves that cycle's length unchanged and takes effect from the next cycle.
- R7: With S = 0, `mod_sel_o` is 0 from the first period of the cycle.
- R8: While reset is asserted, `mod_sel_o` is 1 and `div_pulse_o` is 0. After release, the first cycle starts after one load period.
- R9: The full-width values S = 63 and P up to 8191 are counted without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| p_val_i | input | 13 | Program count P |
| s_val_i | input | 6 | Swallow count S |
| mod_sel_o | output | 1 | 1: prescaler divides by N+1, 0: by N |
| div_pulse_o | output | 1 | High during the first prescaler period of each cycle |

## Verification
The hardest case to bring about is a change of P or S that lands in the middle of a cycle, so that the capture-at-restart rule is actually exercised. The bench reaches it by waiting for a cycle start and letting a few prescaler periods pass. It then changes both values and measures that cycle and the next one separately. Large ratios such as P = 6000, S = 40 and the full swallow width are driven as directed cases through a behavioural prescaler, while random P/S pairs cover the ordinary range.

// File: rtl/swd_pkg.sv
package swd_pkg;
    parameter int unsigned P_WIDTH = 13;
    parameter int unsigned S_WIDTH = 6;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_WIDE   = 2'd1,
        ST_NARROW = 2'd2
    } swd_state_e;
endpackage

// File: rtl/swd_counter.sv
module swd_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] cnt_o,
    output logic         tc_o
);
    localparam int unsigned WX = W + 1;

    logic [W-1:0] cnt_q;
    logic [WX-1:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + WX'(1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= cnt_inc[W-1:0];
        end
    end

    // terminal count: the period now ending is the limit-th one
    assign tc_o  = (cnt_inc == {1'b0, limit_i});
    assign cnt_o = cnt_q;
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl
    import swd_pkg::*;
#(
    parameter int unsigned P_W = swd_pkg::P_WIDTH,
    parameter int unsigned S_W = swd_pkg::S_WIDTH
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [P_W-1:0] p_val_i,
    input  logic [S_W-1:0] s_val_i,
    output logic           mod_sel_o,
    output logic           div_pulse_o
);
    swd_state_e     state_q, state_d;
    logic [P_W-1:0] p_lat_q;
    logic [S_W-1:0] s_lat_q;
    logic [P_W-1:0] p_cnt;
    logic [S_W-1:0] s_cnt;
    logic           p_tc, s_tc;
    logic           restart, load;
    logic           new_s_zero;

    assign restart    = (state_q != ST_LOAD) && p_tc;
    assign load       = (state_q == ST_LOAD) || restart;
    assign new_s_zero = (s_val_i == '0);

    swd_counter #(.W(P_W)) u_prog_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (load),
        .en_i    (1'b1),
        .limit_i (p_lat_q),
        .cnt_o   (p_cnt),
        .tc_o    (p_tc)
    );

    swd_counter #(.W(S_W)) u_swal_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (load),
        .en_i    (state_q == ST_WIDE),
        .limit_i (s_lat_q),
        .cnt_o   (s_cnt),
        .tc_o    (s_tc)
    );

    // programmed values captured at cycle boundaries only
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_lat_q <= '0;
            s_lat_q <= '0;
        end else if (load) begin
            p_lat_q <= p_val_i;
            s_lat_q <= s_val_i;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d = new_s_zero ? ST_NARROW : ST_WIDE;
            end
            ST_WIDE: begin
                if (restart) begin
                    state_d = new_s_zero ? ST_NARROW : ST_WIDE;
                end else if (s_tc) begin
                    state_d = ST_NARROW;
                end
            end
            ST_NARROW: begin
                if (restart) begin
                    state_d = new_s_zero ? ST_NARROW : ST_WIDE;
                end
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        mod_sel_o   = (state_q != ST_NARROW);
        div_pulse_o = (state_q != ST_LOAD) && (p_cnt == '0);
    end

    logic unused_ok;
    assign unused_ok = ^s_cnt;
endmodule

// File: rtl/swallow_div_ctrl_chk.sv
module swallow_div_ctrl_chk #(
    parameter int unsigned P_W = 13,
    parameter int unsigned S_W = 6
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           mod_sel_o,
    input logic           div_pulse_o,
    input logic [P_W-1:0] p_lat,
    input logic [S_W-1:0] s_lat
);
    localparam int unsigned CW = P_W + 1;

    logic          seen_start_q;
    logic [CW-1:0] wide_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_start_q <= 1'b0;
            wide_cnt_q   <= '0;
        end else if (div_pulse_o) begin
            seen_start_q <= 1'b1;
            wide_cnt_q   <= CW'(mod_sel_o);
        end else begin
            wide_cnt_q   <= wide_cnt_q + CW'(mod_sel_o);
        end
    end

    // R2: a cycle with S > 0 opens at N+1
    a_r2_start_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_pulse_o && s_lat != '0) |-> mod_sel_o);

    // R7: S = 0 opens at N
    a_r7_zero_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_pulse_o && s_lat == '0) |-> !mod_sel_o);

    // R4: narrow persists to the end of the cycle
    a_r4_stay_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mod_sel_o) |=> (!mod_sel_o || div_pulse_o));

    // R5: pulse lasts one period when P > 1
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_pulse_o && p_lat > P_W'(1)) |=> !div_pulse_o);

    // R6: latched values hold between starts
    a_r6_hold_values: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div_pulse_o) |-> ($stable(p_lat) && $stable(s_lat)));

    // R3: no more than S wide periods within a cycle
    a_r3_wide_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_start_q && !div_pulse_o) |-> ((wide_cnt_q + CW'(mod_sel_o)) <= CW'(s_lat)));
endmodule

bind swallow_div_ctrl swallow_div_ctrl_chk #(.P_W(P_W), .S_W(S_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mod_sel_o   (mod_sel_o),
    .div_pulse_o (div_pulse_o),
    .p_lat       (p_lat_q),
    .s_lat       (s_lat_q)
);

// File: tb/swallow_div_ctrl_tb.sv
`timescale 1ns/1ps
module swallow_div_ctrl_tb;
    localparam int N      = 16;
    localparam int WD_MAX = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_clk = 1'b0;
    logic [12:0] p_val = 13'd10;
    logic [5:0]  s_val = 6'd3;
    logic        mod_sel, div_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    swallow_div_ctrl u_dut (
        .clk_i       (pre_clk),
        .rst_ni      (rst_n),
        .p_val_i     (p_val),
        .s_val_i     (s_val),
        .mod_sel_o   (mod_sel),
        .div_pulse_o (div_pulse)
    );

    // behavioural N/N+1 prescaler
    int pc = 0;
    int cur_mod = N + 1;
    always @(posedge clk) begin
        if (pc == cur_mod - 1) begin
            pc      <= 0;
            pre_clk <= 1'b1;
        end else begin
            pc      <= pc + 1;
            pre_clk <= (pc == 0);
            if (pc == 4) cur_mod <= mod_sel ? N + 1 : N;
        end
    end

    // cycle monitor, sampled on the falling edge
    int  fcnt = 0, start_t = 0, hi_cnt = 0, per_cnt = 0;
    int  last_len = 0, last_hi = 0, last_per = 0, starts = 0;
    logic pre_q = 1'b0;
    always @(negedge clk) begin
        fcnt = fcnt + 1;
        if (pre_clk && !pre_q && rst_n) begin
            if (div_pulse) begin
                last_len = fcnt - start_t;
                last_hi  = hi_cnt;
                last_per = per_cnt;
                start_t  = fcnt;
                hi_cnt   = mod_sel ? 1 : 0;
                per_cnt  = 1;
                starts   = starts + 1;
            end else begin
                per_cnt = per_cnt + 1;
                hi_cnt  = hi_cnt + (mod_sel ? 1 : 0);
            end
        end
        pre_q = pre_clk;
    end

    function automatic int ratio(int p, int s);
        return N * p + s;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_start();
        int s0 = starts;
        wait (starts == s0 + 1);
    endtask

    task automatic run_case(int p, int s, string tag);
        @(negedge clk);
        p_val = 13'(p);
        s_val = 6'(s);
        wait_start();  // cycle that captured the new values
        wait_start();
        check(last_len == ratio(p, s), {"R1 ratio ", tag}, last_len, ratio(p, s));
        check(last_per == p, {"R3 periods ", tag}, last_per, p);
        check(last_hi == s, {"R3 wide periods ", tag}, last_hi, s);
    endtask

    initial begin
        repeat (WD_MAX) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_MAX, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R8 reset state
        check(mod_sel == 1'b1, "R8 mod_sel in reset", int'(mod_sel), 1);
        check(div_pulse == 1'b0, "R8 pulse in reset", int'(div_pulse), 0);
        rst_n = 1'b1;
        wait_start();
        check(per_cnt == 1 && div_pulse, "R8 first cycle start", per_cnt, 1);

        run_case(10, 3, "p10 s3");
        run_case(9, 0, "R7 s0");
        run_case(12, 11, "s=p-1");
        run_case(1, 0, "p1");
        run_case(64, 63, "R9 s63");
        // R5: pulse held one prescaler period only
        check(last_per == 64, "R5 one pulse per cycle", last_per, 64);

        for (int i = 0; i < 8; i++) begin
            int p = 2 + int'($urandom % 39);
            int s = int'($urandom % p);
            run_case(p, s, $sformatf("rand%0d", i));
        end

        // R6 mid-cycle change
        run_case(10, 3, "A");
        repeat (4) @(posedge pre_clk);
        @(negedge clk);
        p_val = 13'd12;
        s_val = 6'd7;
        wait_start();
        check(last_len == ratio(10, 3), "R6 cycle keeps old values", last_len, ratio(10, 3));
        wait_start();
        check(last_len == ratio(12, 7), "R6 new values next cycle", last_len, ratio(12, 7));

        run_case(6000, 40, "R9 p6000 s40");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule